// File: doc/BRIEF.md
# DMA Request Router and Interrupt Summary

This block sits between a set of peripheral DMA request lines and a bank of DMA channels. Every request line has its own mapping register. That register holds a valid flag and a channel number. On each cycle the router combines all request lines that are validly mapped to the same channel with an OR. The result drives that channel's request output, with one register stage on the way.

The block also collects one interrupt flag from each channel. It shows these flags as a read-only summary word, and it produces a single combined interrupt, also registered, for the interrupt controller. Software programs the mappings through a simple word-addressed register port. Read data is registered.

Top module: `dma_req_router`

## Requirements
- R1: After synchronous reset every mapping register reads 0, and `chan_req` and `irq_out` are 0. Request lines therefore start unrouted.
- R2: A write to word address i (0 to 39) stores bit 7 of `wdata` as the valid flag and bits 3:0 as the channel number. A later read of that address returns these two fields in the same positions and zeros in all other bits. `rdata` is updated at the clock edge that samples `rd_en`.
- R3: When request line i is high and its mapping is valid with channel c, `chan_req[c]` is 1 at the clock edge after the edge that sampled the request. When no request line is high, `chan_req` is 0.
- R4: A request line whose valid flag is clear drives no channel, whatever its channel field holds.
- R5: A channel's request output is the OR of every validly mapped request line that selects it.
- R6: Writing 0 to a mapping register detaches that line from routing from the next cycle on.
- R7: A read of word address 64 returns `irq_in` in bits 15:0, with bit i standing for channel i, and zeros in bits 31:16.
- R8: A write to address 64 has no effect. The summary still mirrors `irq_in`, and no mapping register changes.
- R9: `irq_out` equals the OR of all bits of `irq_in` sampled at the previous clock edge.
- R10: Reads of addresses that hold no register return 0, and writes to them change no mapping.
- R11: Rewriting a mapping with a new channel moves the line's request to the new channel output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 7 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| req_in | input | 40 | Peripheral request lines |
| chan_req | output | 16 | Per-channel request outputs, registered |
| irq_in | input | 16 | Per-channel interrupt flags |
| irq_out | output | 1 | Combined interrupt, registered |

## Verification
A corrupted valid flag or channel field shows up in two places. It appears on the next register read of that line. It also appears one cycle after the line is asserted, as a missing or misplaced bit on `chan_req`. A write decode that wrongly reaches mapping storage appears on the very next readback of an unrelated line. A wrong summary path is caught by one read of address 64 while `irq_in` holds an asymmetric pattern. A fault in the combined interrupt register shows up on `irq_out` within one cycle of `irq_in` changing.

// File: rtl/dmar_pkg.sv
package dmar_pkg;
  // position of the valid flag inside a mapping word; channel field sits at the bottom
  localparam int MAP_VALID_POS = 7;

  typedef enum logic [1:0] {
    RSEL_NONE,
    RSEL_MAP,
    RSEL_SUM
  } rsel_e;
endpackage

// File: rtl/dmar_map_regs.sv
module dmar_map_regs #(
  parameter int N_REQ  = 40,
  parameter int CH_W   = 4,
  parameter int ADDR_W = 7,
  parameter int DATA_W = 32
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [DATA_W-1:0]             wdata,
  output logic [N_REQ-1:0]              map_valid,
  output logic [N_REQ-1:0][CH_W-1:0]    map_chan
);
  import dmar_pkg::*;

  localparam int IDX_W = $clog2(N_REQ);

  logic             hit;
  logic [IDX_W-1:0] idx;

  assign hit = wr_en && (32'(addr) < N_REQ);
  assign idx = addr[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      map_valid <= '0;
      map_chan  <= '0;
    end else if (hit) begin
      map_valid[idx] <= wdata[MAP_VALID_POS];
      map_chan[idx]  <= wdata[CH_W-1:0];
    end
  end
endmodule

// File: rtl/dmar_route.sv
module dmar_route #(
  parameter int N_REQ  = 40,
  parameter int N_CHAN = 16,
  parameter int CH_W   = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [N_REQ-1:0]           req_in,
  input  logic [N_REQ-1:0]           map_valid,
  input  logic [N_REQ-1:0][CH_W-1:0] map_chan,
  output logic [N_CHAN-1:0]          chan_req
);
  logic [N_CHAN-1:0] chan_hit;

  for (genvar c = 0; c < N_CHAN; c++) begin : g_chan
    logic [N_REQ-1:0] sel;
    for (genvar i = 0; i < N_REQ; i++) begin : g_line
      assign sel[i] = req_in[i] && map_valid[i] && (map_chan[i] == CH_W'(c));
    end
    assign chan_hit[c] = |sel;
  end

  always_ff @(posedge clk) begin
    if (rst) chan_req <= '0;
    else     chan_req <= chan_hit;
  end
endmodule

// File: rtl/dmar_irq_sum.sv
module dmar_irq_sum #(
  parameter int N_CHAN = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_CHAN-1:0] irq_in,
  output logic [DATA_W-1:0] sum_word,
  output logic              irq_out
);
  assign sum_word = DATA_W'(irq_in);

  always_ff @(posedge clk) begin
    if (rst) irq_out <= 1'b0;
    else     irq_out <= |irq_in;
  end
endmodule

// File: rtl/dma_req_router.sv
module dma_req_router #(
  parameter int N_REQ   = 40,
  parameter int N_CHAN  = 16,
  parameter int ADDR_W  = 7,
  parameter int DATA_W  = 32,
  parameter int SUM_IDX = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [N_REQ-1:0]  req_in,
  output logic [N_CHAN-1:0] chan_req,
  input  logic [N_CHAN-1:0] irq_in,
  output logic              irq_out
);
  import dmar_pkg::*;

  localparam int CH_W  = $clog2(N_CHAN);
  localparam int IDX_W = $clog2(N_REQ);

  logic [N_REQ-1:0]           map_valid;
  logic [N_REQ-1:0][CH_W-1:0] map_chan;
  logic [DATA_W-1:0]          sum_word;
  rsel_e                      rsel;
  logic [IDX_W-1:0]           ridx;
  logic [DATA_W-1:0]          map_word;

  dmar_map_regs #(.N_REQ(N_REQ), .CH_W(CH_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_map (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .map_valid(map_valid), .map_chan(map_chan)
  );

  dmar_route #(.N_REQ(N_REQ), .N_CHAN(N_CHAN), .CH_W(CH_W)) u_route (
    .clk(clk), .rst(rst), .req_in(req_in), .map_valid(map_valid),
    .map_chan(map_chan), .chan_req(chan_req)
  );

  dmar_irq_sum #(.N_CHAN(N_CHAN), .DATA_W(DATA_W)) u_irq (
    .clk(clk), .rst(rst), .irq_in(irq_in), .sum_word(sum_word), .irq_out(irq_out)
  );

  // read decode
  always_comb begin
    if (32'(addr) < N_REQ)        rsel = RSEL_MAP;
    else if (32'(addr) == SUM_IDX) rsel = RSEL_SUM;
    else                           rsel = RSEL_NONE;
  end

  assign ridx = addr[IDX_W-1:0];

  always_comb begin
    map_word = '0;
    if (rsel == RSEL_MAP) begin
      map_word[MAP_VALID_POS] = map_valid[ridx];
      map_word[CH_W-1:0]      = map_chan[ridx];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      case (rsel)
        RSEL_MAP: rdata <= map_word;
        RSEL_SUM: rdata <= sum_word;
        default:  rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/dmar_checker.sv
module dmar_checker #(
  parameter int N_REQ   = 40,
  parameter int N_CHAN  = 16,
  parameter int ADDR_W  = 7,
  parameter int DATA_W  = 32,
  parameter int SUM_IDX = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] rdata,
  input logic [N_REQ-1:0]  req_in,
  input logic [N_CHAN-1:0] chan_req,
  input logic [N_CHAN-1:0] irq_in,
  input logic              irq_out,
  input logic [N_REQ-1:0]  map_valid
);
  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (chan_req == '0 && irq_out == 1'b0));

  assert_idle_lines_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(req_in) == '0) |-> chan_req == '0);

  assert_no_valid_no_route_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(map_valid) == '0) |-> chan_req == '0);

  assert_map_read_clean_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(rd_en) && 32'($past(addr)) < N_REQ) |->
      (rdata[DATA_W-1:8] == '0 && rdata[6:4] == '0));

  assert_summary_mirror_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(rd_en) && 32'($past(addr)) == SUM_IDX) |->
      (rdata[N_CHAN-1:0] == $past(irq_in) && rdata[DATA_W-1:N_CHAN] == '0));

  assert_summary_write_inert_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wr_en) && 32'($past(addr)) == SUM_IDX) |-> $stable(map_valid));

  assert_irq_combined_R9: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> irq_out == (|$past(irq_in)));
endmodule

bind dma_req_router dmar_checker #(
  .N_REQ(N_REQ), .N_CHAN(N_CHAN), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SUM_IDX(SUM_IDX)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .rdata(rdata),
  .req_in(req_in), .chan_req(chan_req), .irq_in(irq_in), .irq_out(irq_out),
  .map_valid(map_valid)
);

// File: tb/dma_req_router_tb.sv
module dma_req_router_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [6:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [39:0] req_in = '0;
  logic [15:0] chan_req;
  logic [15:0] irq_in = '0;
  logic        irq_out;

  int total = 0;
  int bad = 0;
  logic [31:0] rd_val;

  always #5 clk = ~clk;

  dma_req_router u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .req_in(req_in), .chan_req(chan_req), .irq_in(irq_in), .irq_out(irq_out)
  );

  typedef struct packed {
    logic [39:0] req;
    logic [15:0] exp;
  } vec_t;

  // mapping used: line0,1->ch3, line2->ch15, line3 invalid(ch5), line20->ch0, line39->ch9
  localparam vec_t VEC [9] = '{
    '{40'h00_0000_0000, 16'h0000},
    '{40'h00_0000_0001, 16'h0008},
    '{40'h00_0000_0003, 16'h0008},
    '{40'h00_0000_0004, 16'h8000},
    '{40'h00_0000_0008, 16'h0000},
    '{40'h80_0000_0000, 16'h0200},
    '{40'h00_0010_0000, 16'h0001},
    '{40'hFF_FFFF_FFFF, 16'h8209},
    '{40'h00_0000_0400, 16'h0000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic route(input logic [39:0] r, input logic [15:0] exp, input string req);
    @(negedge clk);
    req_in = r;
    @(negedge clk);
    check(req, 32'(chan_req), 32'(exp));
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #2000000;
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    irq_in = 16'hFFFF;
    req_in = '1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: outputs cleared by reset (sampled before the first post-reset edge acts)
    check("R1 chan_req", 32'(chan_req), 32'h0);
    check("R1 irq_out", 32'(irq_out), 32'h0);
    irq_in = '0;
    req_in = '0;
    rd(7'd0, rd_val);  check("R1 map0", rd_val, 32'h0);
    rd(7'd39, rd_val); check("R1 map39", rd_val, 32'h0);
    route(40'hFF_FFFF_FFFF, 16'h0000, "R1 unrouted after reset");

    // R2: mapping writes and readback
    wr(7'd0, 32'h0000_0083);
    wr(7'd1, 32'h0000_0083);
    wr(7'd2, 32'hFFFF_FFFF);
    wr(7'd3, 32'h0000_0005);
    wr(7'd20, 32'h0000_0080);
    wr(7'd39, 32'h0000_0089);
    rd(7'd0, rd_val);  check("R2 map0", rd_val, 32'h83);
    rd(7'd2, rd_val);  check("R2 map2 masked", rd_val, 32'h8F);
    rd(7'd3, rd_val);  check("R2 map3", rd_val, 32'h05);

    // table: R3 single routes, R4 invalid line, R5 shared channel
    for (int k = 0; k < 9; k++) begin
      route(VEC[k].req, VEC[k].exp, "R3/R4/R5 vector");
    end
    route(40'h00_0000_0008, 16'h0000, "R4 invalid line");
    route(40'h00_0000_0003, 16'h0008, "R5 shared channel");

    // R6: detach by writing 0
    wr(7'd0, 32'h0);
    route(40'h00_0000_0001, 16'h0000, "R6 detached line");
    rd(7'd0, rd_val); check("R6 map0 cleared", rd_val, 32'h0);
    route(40'h00_0000_0003, 16'h0008, "R6 other line still routed");

    // R11: remap
    wr(7'd39, 32'h0000_0084);
    route(40'h80_0000_0000, 16'h0010, "R11 remapped line");
    req_in = '0;

    // R7 / R9: summary and combined interrupt
    @(negedge clk);
    irq_in = 16'hA005;
    @(negedge clk);
    check("R9 irq_out high", 32'(irq_out), 32'h1);
    rd(7'd64, rd_val); check("R7 summary", rd_val, 32'h0000_A005);
    irq_in = 16'h0000;
    @(negedge clk);
    check("R9 irq_out low", 32'(irq_out), 32'h0);
    irq_in = 16'h8000;
    @(negedge clk);
    check("R9 top channel", 32'(irq_out), 32'h1);

    // R8: writes to summary ignored
    irq_in = 16'h0001;
    wr(7'd64, 32'hFFFF_FFFF);
    rd(7'd64, rd_val); check("R8 summary unchanged", rd_val, 32'h0000_0001);
    rd(7'd20, rd_val); check("R8 map20 intact", rd_val, 32'h80);

    // R10: unmapped addresses
    wr(7'd50, 32'h0000_00FF);
    rd(7'd50, rd_val); check("R10 hole reads 0", rd_val, 32'h0);
    rd(7'd20, rd_val); check("R10 map20 intact", rd_val, 32'h80);
    route(40'h00_0010_0000, 16'h0001, "R10 routing intact");

    req_in = '0;
    irq_in = '0;
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule